// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block keeps one interrupt mailbox for every CPU in the system. A system bus presents interrupt arrivals. Each arrival names a target CPU and a source ID, and it carries two 64-bit data words. When the target mailbox is free, the block accepts the arrival in the same cycle. It stores the source ID and both data words, marks the mailbox busy, and one cycle later posts an interrupt to that CPU. The interrupt carries a single programmable vector that all bus interrupts share. When the target mailbox is busy, the block refuses the arrival and changes nothing, so the sender can retry later.

Software reaches the block through a simple register port with a one-cycle read latency. It can read each CPU's data words and status through indexed arrays. It can also use alias offsets, which pick the mailbox of the CPU that issues the request. Software frees a mailbox by writing 0 to the busy bit.

Top module: `irq_mailbox_bank`

## Requirements
- R1: While reset is asserted, and once it is released, every mailbox is free and every readable location reads 0. The shared vector, `post_valid` and `sw_rdata` are also 0.
- R2: An arrival whose target mailbox is free raises `arr_ready` in the same cycle as `arr_valid`. From the next cycle on, the status of that CPU reads busy at bit 5 and the source ID in bits 4:0, and both data words read back as delivered.
- R3: An arrival whose target mailbox is busy sees `arr_ready` low. The stored source ID and data words stay unchanged, and no post follows.
- R4: In the cycle after an acceptance, `post_valid` is 1 for one cycle. `post_cpu` carries the target, and `post_vec` carries the vector value held before any write in the accepting cycle. In every other cycle `post_valid` is 0.
- R5: The shared vector sits at offset 0x318. A write loads it from bits 5:0 of the write data, and a read returns it zero-extended.
- R6: A write to a status location loads busy from bit 5 of the write data and leaves the source ID and data words unchanged. Writing 0 frees the mailbox. Writing 1 makes it refuse arrivals.
- R7: Data word 0 of CPU n sits at 0x000+8n, data word 1 at 0x100+8n and status at 0x200+8n. Data words are read-only, so writes to them are ignored. An offset whose low three bits are not zero selects nothing and reads 0.
- R8: Offsets 0x300, 0x308 and 0x310 access data word 0, data word 1 and status of the CPU given on `sw_cpu`. The status alias is writable.
- R9: If, in one cycle, a status write frees a mailbox and an arrival targets it, the write takes effect first. The arrival is then accepted, and its source and data are stored.
- R10: `sw_rdata` loads the selected value at the clock edge of a read request and holds through idle cycles and writes. A CPU index at or above the CPU count, whether indexed or through the alias, reads 0, and writes to it are ignored.
- R11: An arrival naming a CPU at or above the CPU count is refused and produces no post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 1 | Bus interrupt arrival presented |
| arr_cpu | input | CPU_W | Target CPU of the arrival |
| arr_src | input | SRC_W | Source ID of the arrival |
| arr_d0 | input | DATA_W | First data word of the arrival |
| arr_d1 | input | DATA_W | Second data word of the arrival |
| arr_ready | output | 1 | Arrival accepted this cycle |
| post_valid | output | 1 | Interrupt post to a CPU |
| post_cpu | output | CPU_W | CPU receiving the post |
| post_vec | output | VEC_W | Vector carried by the post |
| sw_req | input | 1 | Software access request |
| sw_we | input | 1 | Access is a write |
| sw_cpu | input | CPU_W | CPU issuing the access (selects alias entries) |
| sw_addr | input | ADDR_W | Byte offset of the access |
| sw_wdata | input | DATA_W | Write data |
| sw_rdata | output | DATA_W | Read data, valid the cycle after a read request |

## Verification
The hardest case to reach from the ports is a software write and an arrival meeting on the same mailbox in the same clock. A bench that drives one interface at a time never reaches it. The stimulus first fills a mailbox. Then, in a single cycle, it drives a busy-clearing status write together with a new arrival for that CPU, and it reads the status back to confirm that the new source was stored. A related case drives a vector write together with an accepted arrival, to show that the post carries the old vector.

// File: rtl/irq_mbx_pkg.sv
package irq_mbx_pkg;

  // Address regions, taken from the top two offset bits
  typedef enum logic [1:0] {
    RG_DATA0 = 2'd0,
    RG_DATA1 = 2'd1,
    RG_STAT  = 2'd2,
    RG_MISC  = 2'd3
  } region_e;

  // Slots inside the misc region (offset bits above the 8-byte word)
  localparam int unsigned MS_ALIAS_D0 = 0;
  localparam int unsigned MS_ALIAS_D1 = 1;
  localparam int unsigned MS_ALIAS_ST = 2;
  localparam int unsigned MS_VECTOR   = 3;

  // Decoded target of a software access
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_D0   = 3'd1,
    SEL_D1   = 3'd2,
    SEL_STAT = 3'd3,
    SEL_VEC  = 3'd4
  } sel_e;

  // Position of the busy flag in a status word
  localparam int unsigned BUSY_BIT = 5;

endpackage

// File: rtl/irq_mbx_decode.sv
module irq_mbx_decode
  import irq_mbx_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_W   = 3,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output sel_e              sel,
  output logic [CPU_W-1:0]  idx,
  output logic              idx_ok
);

  localparam int unsigned FIELD_W = ADDR_W - 5;

  region_e            region;
  logic [FIELD_W-1:0] field;
  logic               aligned;
  logic               field_ok;
  logic               cpu_ok;

  always_comb begin
    region   = region_e'(addr[ADDR_W-1 -: 2]);
    field    = addr[ADDR_W-3:3];
    aligned  = (addr[2:0] == 3'd0);
    field_ok = (int'(field) < int'(NUM_CPU));
    cpu_ok   = (int'(req_cpu) < int'(NUM_CPU));
  end

  always_comb begin
    sel    = SEL_NONE;
    idx    = field[CPU_W-1:0];
    idx_ok = field_ok;
    if (aligned) begin
      unique case (region)
        RG_DATA0: sel = SEL_D0;
        RG_DATA1: sel = SEL_D1;
        RG_STAT:  sel = SEL_STAT;
        RG_MISC: begin
          idx    = req_cpu;
          idx_ok = cpu_ok;
          if (int'(field) == int'(MS_ALIAS_D0))      sel = SEL_D0;
          else if (int'(field) == int'(MS_ALIAS_D1)) sel = SEL_D1;
          else if (int'(field) == int'(MS_ALIAS_ST)) sel = SEL_STAT;
          else if (int'(field) == int'(MS_VECTOR)) begin
            sel    = SEL_VEC;
            idx_ok = 1'b1;
          end
        end
        default: sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_mbx_slot.sv
module irq_mbx_slot #(
  parameter int unsigned SRC_W  = 5,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_hit,
  input  logic [SRC_W-1:0]  arr_src,
  input  logic [DATA_W-1:0] arr_d0,
  input  logic [DATA_W-1:0] arr_d1,
  input  logic              wr_hit,
  input  logic              wr_busy,
  output logic              take,
  output logic              busy,
  output logic [SRC_W-1:0]  src,
  output logic [DATA_W-1:0] d0,
  output logic [DATA_W-1:0] d1
);

  logic              busy_q, busy_d, busy_en, busy_eff;
  logic [SRC_W-1:0]  src_q;
  logic [DATA_W-1:0] d0_q, d1_q;

  // A software write in the same cycle is applied before the arrival is judged
  always_comb begin
    busy_eff = wr_hit ? wr_busy : busy_q;
    take     = arr_hit & ~busy_eff;
    busy_en  = take | wr_hit;
    busy_d   = take ? 1'b1 : wr_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else if (take) begin
      src_q <= arr_src;
      d0_q  <= arr_d0;
      d1_q  <= arr_d1;
    end
  end

  assign busy = busy_q;
  assign src  = src_q;
  assign d0   = d0_q;
  assign d1   = d1_q;

endmodule

// File: rtl/irq_mbx_rdmux.sv
module irq_mbx_rdmux
  import irq_mbx_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_W   = 3,
  parameter int unsigned SRC_W   = 5,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VEC_W   = 6
) (
  input  sel_e              sel,
  input  logic [CPU_W-1:0]  idx,
  input  logic              idx_ok,
  input  logic [NUM_CPU-1:0] busy_vec,
  input  logic [SRC_W-1:0]  src_arr [NUM_CPU],
  input  logic [DATA_W-1:0] d0_arr  [NUM_CPU],
  input  logic [DATA_W-1:0] d1_arr  [NUM_CPU],
  input  logic [VEC_W-1:0]  vec,
  output logic [DATA_W-1:0] value
);

  logic [DATA_W-1:0] pick_d0, pick_d1, pick_st;

  always_comb begin
    pick_d0 = '0;
    pick_d1 = '0;
    pick_st = '0;
    for (int i = 0; i < int'(NUM_CPU); i++) begin
      if (idx == CPU_W'(i)) begin
        pick_d0 = d0_arr[i];
        pick_d1 = d1_arr[i];
        pick_st[SRC_W-1:0] = src_arr[i];
        pick_st[BUSY_BIT]  = busy_vec[i];
      end
    end
  end

  always_comb begin
    value = '0;
    unique case (sel)
      SEL_D0:   if (idx_ok) value = pick_d0;
      SEL_D1:   if (idx_ok) value = pick_d1;
      SEL_STAT: if (idx_ok) value = pick_st;
      SEL_VEC:  value[VEC_W-1:0] = vec;
      default:  value = '0;
    endcase
  end

endmodule

// File: rtl/irq_mailbox_bank.sv
module irq_mailbox_bank
  import irq_mbx_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_W   = 3,
  parameter int unsigned SRC_W   = 5,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VEC_W   = 6,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  logic [CPU_W-1:0]  arr_cpu,
  input  logic [SRC_W-1:0]  arr_src,
  input  logic [DATA_W-1:0] arr_d0,
  input  logic [DATA_W-1:0] arr_d1,
  output logic              arr_ready,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec,
  input  logic              sw_req,
  input  logic              sw_we,
  input  logic [CPU_W-1:0]  sw_cpu,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata
);

  // ---------------- software access decode ----------------
  sel_e             sel;
  logic [CPU_W-1:0] idx;
  logic             idx_ok;

  irq_mbx_decode #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)
  ) decode_i (
    .addr(sw_addr), .req_cpu(sw_cpu),
    .sel(sel), .idx(idx), .idx_ok(idx_ok)
  );

  logic stat_wr, vec_wr, rd_en;
  logic wr_busy_bit;
  logic unused_wdata;

  always_comb begin
    stat_wr     = sw_req & sw_we & (sel == SEL_STAT) & idx_ok;
    vec_wr      = sw_req & sw_we & (sel == SEL_VEC);
    rd_en       = sw_req & ~sw_we;
    wr_busy_bit = sw_wdata[BUSY_BIT];
  end

  assign unused_wdata = ^{sw_wdata[DATA_W-1:BUSY_BIT+1], sw_wdata[BUSY_BIT-1:VEC_W]};

  // ---------------- per-CPU mailboxes ----------------
  logic [NUM_CPU-1:0] take_vec;
  logic [NUM_CPU-1:0] busy_vec;
  logic [SRC_W-1:0]   src_arr [NUM_CPU];
  logic [DATA_W-1:0]  d0_arr  [NUM_CPU];
  logic [DATA_W-1:0]  d1_arr  [NUM_CPU];

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    logic hit_arr, hit_wr;
    assign hit_arr = arr_valid & (arr_cpu == CPU_W'(g));
    assign hit_wr  = stat_wr & (idx == CPU_W'(g));

    irq_mbx_slot #(
      .SRC_W(SRC_W), .DATA_W(DATA_W)
    ) slot_i (
      .clk(clk), .rst_n(rst_n),
      .arr_hit(hit_arr), .arr_src(arr_src),
      .arr_d0(arr_d0), .arr_d1(arr_d1),
      .wr_hit(hit_wr), .wr_busy(wr_busy_bit),
      .take(take_vec[g]), .busy(busy_vec[g]),
      .src(src_arr[g]), .d0(d0_arr[g]), .d1(d1_arr[g])
    );
  end

  assign arr_ready = |take_vec;

  // ---------------- shared vector register ----------------
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb vec_d = sw_wdata[VEC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_wr) begin
      vec_q <= vec_d;
    end
  end

  // ---------------- interrupt post ----------------
  logic             post_valid_q, post_valid_d;
  logic [CPU_W-1:0] post_cpu_q, post_cpu_d;
  logic [VEC_W-1:0] post_vec_q, post_vec_d;
  logic             post_ld;

  always_comb begin
    post_valid_d = arr_ready;
    post_ld      = arr_ready;
    post_cpu_d   = arr_cpu;
    post_vec_d   = vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_valid_q <= 1'b0;
    end else begin
      post_valid_q <= post_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cpu_q <= '0;
      post_vec_q <= '0;
    end else if (post_ld) begin
      post_cpu_q <= post_cpu_d;
      post_vec_q <= post_vec_d;
    end
  end

  assign post_valid = post_valid_q;
  assign post_cpu   = post_cpu_q;
  assign post_vec   = post_vec_q;

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_value;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  irq_mbx_rdmux #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .SRC_W(SRC_W),
    .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) rdmux_i (
    .sel(sel), .idx(idx), .idx_ok(idx_ok),
    .busy_vec(busy_vec), .src_arr(src_arr),
    .d0_arr(d0_arr), .d1_arr(d1_arr),
    .vec(vec_q), .value(rd_value)
  );

  always_comb rdata_d = rd_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign sw_rdata = rdata_q;

endmodule

// File: rtl/irq_mailbox_bank_chk.sv
module irq_mailbox_bank_chk #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arr_valid,
  input logic [CPU_W-1:0]   arr_cpu,
  input logic               arr_ready,
  input logic               post_valid,
  input logic [CPU_W-1:0]   post_cpu,
  input logic               sw_req,
  input logic               sw_we,
  input logic [NUM_CPU-1:0] busy_vec
);

  logic sw_write;
  logic tgt_busy;
  logic tgt_in_range;

  always_comb begin
    sw_write     = sw_req & sw_we;
    tgt_busy     = |(busy_vec & (NUM_CPU'(1) << arr_cpu));
    tgt_in_range = (int'(arr_cpu) < int'(NUM_CPU));
  end

  // R2: acceptance only for a presented arrival
  assert_ready_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_ready |-> arr_valid);

  // R2: accepted target reads busy afterwards
  assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_ready |=> |(busy_vec & (NUM_CPU'(1) << $past(arr_cpu))));

  // R3: busy target with no software write is refused
  assert_refuse_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && tgt_busy && !sw_write) |-> !arr_ready);

  // R11: out-of-range target never accepted
  assert_refuse_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !tgt_in_range) |-> !arr_ready);

  // R4: post follows acceptance to the same CPU
  assert_post_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_ready |=> (post_valid && post_cpu == $past(arr_cpu)));

  // R4: no post without acceptance
  assert_no_stray_post_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_ready |=> !post_valid);

  // R6: busy flags move only by acceptance or software write
  assert_busy_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!arr_ready && !sw_write) |=> $stable(busy_vec));

endmodule

bind irq_mailbox_bank irq_mailbox_bank_chk #(
  .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .arr_valid(arr_valid), .arr_cpu(arr_cpu), .arr_ready(arr_ready),
  .post_valid(post_valid), .post_cpu(post_cpu),
  .sw_req(sw_req), .sw_we(sw_we), .busy_vec(busy_vec)
);

// File: tb/irq_mailbox_bank_tb.sv
module irq_mailbox_bank_tb_top;

  localparam int NUM_CPU = 4;
  localparam int CPU_W   = 3;
  localparam int SRC_W   = 5;
  localparam int DATA_W  = 64;
  localparam int VEC_W   = 6;
  localparam int ADDR_W  = 10;

  localparam logic [1:0] K_RD = 2'd0;
  localparam logic [1:0] K_WR = 2'd1;
  localparam logic [1:0] K_AR = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  cpu;
    logic [9:0]  addr;
    logic [15:0] w;
    logic [63:0] exp;   // read: expected rdata; arrival: expected post_vec
    logic        rdy;   // arrival: expected arr_ready
    logic [3:0]  req;   // requirement number for messages
  } step_t;

  localparam int NSTEP = 28;
  localparam step_t TBL [NSTEP] = '{
    '{K_RD, 3'd0, 10'h318, 16'h0000, 64'h0, 1'b0, 4'd1},                 // R1 vector 0
    '{K_WR, 3'd0, 10'h318, 16'h03E5, 64'h0, 1'b0, 4'd5},                 // R5 write vector
    '{K_RD, 3'd0, 10'h318, 16'h0000, 64'h25, 1'b0, 4'd5},                // R5 low six bits kept
    '{K_AR, 3'd1, 10'h000, 16'h0F03, 64'h25, 1'b1, 4'd2},                // R2 accept cpu1
    '{K_RD, 3'd0, 10'h208, 16'h0000, 64'h23, 1'b0, 4'd2},                // R2 status
    '{K_RD, 3'd0, 10'h008, 16'h0000, 64'h0F030F030F030F03, 1'b0, 4'd7},  // R7 word0
    '{K_RD, 3'd0, 10'h108, 16'h0000, 64'hF0FCF0FCF0FCF0FC, 1'b0, 4'd7},  // R7 word1
    '{K_AR, 3'd1, 10'h000, 16'h1111, 64'h0, 1'b0, 4'd3},                 // R3 refused
    '{K_RD, 3'd0, 10'h208, 16'h0000, 64'h23, 1'b0, 4'd3},                // R3 status kept
    '{K_RD, 3'd0, 10'h008, 16'h0000, 64'h0F030F030F030F03, 1'b0, 4'd3},  // R3 data kept
    '{K_AR, 3'd2, 10'h000, 16'h2222, 64'h25, 1'b1, 4'd2},                // R2 accept cpu2
    '{K_RD, 3'd2, 10'h310, 16'h0000, 64'h22, 1'b0, 4'd8},                // R8 alias status
    '{K_RD, 3'd2, 10'h300, 16'h0000, 64'h2222222222222222, 1'b0, 4'd8},  // R8 alias word0
    '{K_RD, 3'd2, 10'h308, 16'h0000, 64'hDDDDDDDDDDDDDDDD, 1'b0, 4'd8},  // R8 alias word1
    '{K_RD, 3'd1, 10'h310, 16'h0000, 64'h23, 1'b0, 4'd8},                // R8 alias other cpu
    '{K_WR, 3'd0, 10'h208, 16'hFFDF, 64'h0, 1'b0, 4'd6},                 // R6 free cpu1
    '{K_RD, 3'd0, 10'h208, 16'h0000, 64'h03, 1'b0, 4'd6},                // R6 source kept
    '{K_WR, 3'd2, 10'h310, 16'h0000, 64'h0, 1'b0, 4'd8},                 // R8 alias free
    '{K_RD, 3'd0, 10'h210, 16'h0000, 64'h02, 1'b0, 4'd8},                // R8 cpu2 freed
    '{K_WR, 3'd0, 10'h218, 16'h0020, 64'h0, 1'b0, 4'd6},                 // R6 set busy cpu3
    '{K_RD, 3'd0, 10'h218, 16'h0000, 64'h20, 1'b0, 4'd6},                // R6 busy by software
    '{K_AR, 3'd3, 10'h000, 16'h0505, 64'h0, 1'b0, 4'd6},                 // R6 refuse after set
    '{K_AR, 3'd5, 10'h000, 16'h0606, 64'h0, 1'b0, 4'd11},                // R11 out of range
    '{K_RD, 3'd0, 10'h228, 16'h0000, 64'h0, 1'b0, 4'd10},                // R10 index 5 reads 0
    '{K_WR, 3'd0, 10'h008, 16'hBEEF, 64'h0, 1'b0, 4'd7},                 // R7 data read-only
    '{K_RD, 3'd0, 10'h008, 16'h0000, 64'h0F030F030F030F03, 1'b0, 4'd7},  // R7 unchanged
    '{K_AR, 3'd1, 10'h000, 16'h0A0A, 64'h25, 1'b1, 4'd6},                // R6 freed accepts
    '{K_RD, 3'd0, 10'h208, 16'h0000, 64'h2A, 1'b0, 4'd2}                 // R2 new status
  };

  logic              clk;
  logic              rst_n;
  logic              arr_valid;
  logic [CPU_W-1:0]  arr_cpu;
  logic [SRC_W-1:0]  arr_src;
  logic [DATA_W-1:0] arr_d0, arr_d1;
  logic              arr_ready;
  logic              post_valid;
  logic [CPU_W-1:0]  post_cpu;
  logic [VEC_W-1:0]  post_vec;
  logic              sw_req, sw_we;
  logic [CPU_W-1:0]  sw_cpu;
  logic [ADDR_W-1:0] sw_addr;
  logic [DATA_W-1:0] sw_wdata;
  logic [DATA_W-1:0] sw_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  irq_mailbox_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .arr_valid(arr_valid), .arr_cpu(arr_cpu), .arr_src(arr_src),
    .arr_d0(arr_d0), .arr_d1(arr_d1), .arr_ready(arr_ready),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
    .sw_req(sw_req), .sw_we(sw_we), .sw_cpu(sw_cpu), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arrive(input logic [2:0] cpu, input logic [15:0] w, input bit rdy,
                        input logic [5:0] vec, input string req);
    @(negedge clk);
    arr_valid = 1'b1;
    arr_cpu   = cpu;
    arr_src   = w[4:0];
    arr_d0    = {4{w}};
    arr_d1    = ~{4{w}};
    #1;
    check(arr_ready == rdy, req, 64'(arr_ready), 64'(rdy));
    @(negedge clk);
    arr_valid = 1'b0;
    check(post_valid == rdy, req, 64'(post_valid), 64'(rdy));
    if (rdy) begin
      check(post_cpu == cpu, req, 64'(post_cpu), 64'(cpu));
      check(post_vec == vec, req, 64'(post_vec), 64'(vec));
    end
  endtask

  task automatic sw_write(input logic [2:0] cpu, input logic [9:0] addr,
                          input logic [15:0] data);
    @(negedge clk);
    sw_req = 1'b1; sw_we = 1'b1; sw_cpu = cpu; sw_addr = addr;
    sw_wdata = {48'hFFFF_0000_FFFF, data};
    @(negedge clk);
    sw_req = 1'b0; sw_we = 1'b0;
  endtask

  task automatic sw_read(input logic [2:0] cpu, input logic [9:0] addr,
                         input logic [63:0] exp, input string req);
    @(negedge clk);
    sw_req = 1'b1; sw_we = 1'b0; sw_cpu = cpu; sw_addr = addr;
    @(negedge clk);
    sw_req = 1'b0;
    check(sw_rdata == exp, req, sw_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    arr_valid = 1'b0; arr_cpu = '0; arr_src = '0; arr_d0 = '0; arr_d1 = '0;
    sw_req = 1'b0; sw_we = 1'b0; sw_cpu = '0; sw_addr = '0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(post_valid == 1'b0, "R1", 64'(post_valid), 64'd0);
    check(sw_rdata == '0, "R1", sw_rdata, 64'd0);
    rst_n = 1'b1;
    sw_read(3'd0, 10'h200, 64'h0, "R1");
    sw_read(3'd0, 10'h000, 64'h0, "R1");

    // table walk
    for (int i = 0; i < NSTEP; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", TBL[i].req, i);
      case (TBL[i].kind)
        K_RD: sw_read(TBL[i].cpu, TBL[i].addr, TBL[i].exp, tag);
        K_WR: sw_write(TBL[i].cpu, TBL[i].addr, TBL[i].w);
        default: arrive(TBL[i].cpu, TBL[i].w, TBL[i].rdy, TBL[i].exp[5:0], tag);
      endcase
    end

    // R7: misaligned offset selects nothing
    sw_read(3'd0, 10'h209, 64'h0, "R7");
    // R10: alias with out-of-range requester reads 0
    sw_read(3'd5, 10'h310, 64'h0, "R10");

    // R4: vector write in the accepting cycle; post carries old vector
    @(negedge clk);
    sw_req = 1'b1; sw_we = 1'b1; sw_cpu = 3'd0; sw_addr = 10'h318; sw_wdata = 64'h11;
    arr_valid = 1'b1; arr_cpu = 3'd2; arr_src = 5'd4;
    arr_d0 = 64'h44; arr_d1 = ~64'h44;
    #1;
    check(arr_ready == 1'b1, "R4", 64'(arr_ready), 64'd1);
    @(negedge clk);
    sw_req = 1'b0; sw_we = 1'b0; arr_valid = 1'b0;
    check(post_vec == 6'h25, "R4", 64'(post_vec), 64'h25);
    @(negedge clk);
    check(post_valid == 1'b0, "R4 single pulse", 64'(post_valid), 64'd0);
    arrive(3'd0, 16'h0046, 1'b1, 6'h11, "R4 new vector");

    // R9: free and arrival on cpu0 in one cycle
    @(negedge clk);
    sw_req = 1'b1; sw_we = 1'b1; sw_cpu = 3'd0; sw_addr = 10'h200; sw_wdata = 64'h0;
    arr_valid = 1'b1; arr_cpu = 3'd0; arr_src = 5'd7;
    arr_d0 = 64'h77; arr_d1 = 64'h78;
    #1;
    check(arr_ready == 1'b1, "R9", 64'(arr_ready), 64'd1);
    @(negedge clk);
    sw_req = 1'b0; sw_we = 1'b0; arr_valid = 1'b0;
    sw_read(3'd0, 10'h200, 64'h27, "R9");
    sw_read(3'd0, 10'h100, 64'h78, "R9");

    // R10: read data holds through idle and writes
    sw_read(3'd0, 10'h200, 64'h27, "R10");
    @(negedge clk);
    sw_write(3'd0, 10'h318, 16'h0011);
    check(sw_rdata == 64'h27, "R10 hold", sw_rdata, 64'h27);

    // R1: mid-run reset clears everything
    do_reset();
    check(post_valid == 1'b0, "R1", 64'(post_valid), 64'd0);
    sw_read(3'd0, 10'h200, 64'h0, "R1");
    sw_read(3'd0, 10'h318, 64'h0, "R1");
    sw_read(3'd0, 10'h008, 64'h0, "R1");
    arrive(3'd1, 16'h0101, 1'b1, 6'h00, "R1 freed after reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule